// File: doc/BRIEF.md
# PCI Message Signalled Interrupt Capability and Dispatcher

This block holds the registers of a PCI message-signalled-interrupt capability and turns interrupt requests from the device core into memory-write requests. Configuration software reaches the registers with dword reads and writes. Each access carries a dword index relative to the capability base and four byte enables. The device core raises a request by presenting a vector number for one cycle. Depending on the per-vector mask, the block either sends a message write with a programmed address and data, or records the vector as pending.

Three build parameters set the register layout: 32-bit or 64-bit message addresses, whether per-vector masking exists, and the supported vector count. The count is a power of two from 1 to 32. A vector that is masked when its request arrives stays pending. It is sent later, when software writes the control word or the mask register while the capability is enabled and the vector is no longer masked. Outgoing messages leave one at a time on a valid/ready handshake. If several vectors are waiting, the lowest-numbered one goes first.

Top module: `msi_cap_dispatch`

## Requirements
- R1: After reset, dword 0 reads 0x0005 in bits 15:0. Its upper half holds the control word: bit 16 enable = 0, bits 19:17 = log2 of the capable count, bits 22:20 = log2 of the enabled count = 0, bit 23 = 64-bit option, bit 24 = mask option. The address, data, mask and pending registers read 0. msg_valid and vec_err are 0.
- R2: In the control word, a write with byte enable 2 changes only the enable bit (dword bit 16) and the enabled-count field (dword bits 22:20). An enabled count above the capable count is stored as the capable count. Byte 3 has no writable bits.
- R3: Dword 1 holds the lower address and bits 1:0 read 0. In the 64-bit layout, dword 2 is the upper address, dword 3 holds the 16-bit data register in bits 15:0, dword 4 is the mask and dword 5 is the pending register. Only mask bits of implemented vectors can be written. The pending register is read-only.
- R4: The capability is 0x0A, 0x0E, 0x14 or 0x18 bytes long, for 32-bit/no mask, 64-bit/no mask, 32-bit/mask and 64-bit/mask. A dword whose byte offset is at or beyond that length reads 0, and writes to it change nothing.
- R5: If the capability is enabled, a legal unmasked request sampled at clock edge k raises msg_valid after edge k+1, provided the output is free.
- R6: Message data has bits 31:16 at zero and bits 15:0 from the data register. When the enabled count N is above 1, the low log2(N) bits are replaced by the vector number.
- R7: A legal request for a masked vector sets that vector's pending bit and sends no message.
- R8: A write that touches the control word or the mask register, made while the capability is enabled after the write, clears every pending bit whose vector is now unmasked and sends those vectors in ascending order. With the capability disabled, such writes leave pending bits alone.
- R9: A request whose vector is at or above the enabled count is dropped and sets vec_err, which stays set until reset.
- R10: A request that arrives while the capability is disabled is dropped. It sends nothing, sets no pending bit and raises no error.
- R11: While msg_valid is high and msg_ready low, msg_valid, msg_addr and msg_data hold. Only one message is outstanding.
- R12: Waiting vectors are sent lowest number first. A second request for a vector that is already waiting is merged into the first.
- R13: msg_addr carries the upper address in bits 63:32 and the lower address in bits 31:0 in the 64-bit layout. In the 32-bit layout bits 63:32 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_dw | input | 6 | Dword index relative to the capability base |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_dw, combinational |
| irq_valid | input | 1 | Interrupt request strobe from the device core |
| irq_vec | input | 5 | Requested vector number |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message write request accepted |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message data |
| vec_err | output | 1 | Sticky flag: an illegal vector was requested |

## Verification
A wrong pending or waiting bitmap has two visible symptoms. A message can go missing or be duplicated, or messages can leave in the wrong vector order. The bench compares the handshake, address and data with its model every cycle, so such a fault shows within one or two cycles of the replay or grant that exposes it. A wrong mask or enabled-count register shows up in the next readback and in the data bits that carry the vector number. A stale registered replay trigger shows up as a message one cycle early or late.

// File: rtl/msi_pkg.sv
package msi_pkg;

    localparam int MAX_VEC = 32;
    localparam int VEC_W   = 5;

    typedef struct packed {
        logic               en;
        logic [2:0]         enl;
        logic [29:0]        alo;
        logic [31:0]        ahi;
        logic [15:0]        dat;
        logic [MAX_VEC-1:0] mask;
        logic               trig;
    } cfg_st_t;

    typedef struct packed {
        logic [MAX_VEC-1:0] pend;
        logic [MAX_VEC-1:0] queue;
        logic               err;
    } trk_st_t;

    typedef struct packed {
        logic        valid;
        logic [63:0] addr;
        logic [31:0] data;
    } msg_st_t;

    function automatic logic [7:0] cap_len(input bit a64, input bit msk);
        logic [7:0] r;
        case ({a64, msk})
            2'b00:   r = 8'h0A;
            2'b10:   r = 8'h0E;
            2'b01:   r = 8'h14;
            default: r = 8'h18;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] byte_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  be);
        logic [31:0] r;
        r = old_v;
        for (int i = 0; i < 4; i++) begin
            if (be[i]) r[8*i +: 8] = new_v[8*i +: 8];
        end
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] onehot_index(input logic [MAX_VEC-1:0] oh);
        logic [VEC_W-1:0] r;
        r = '0;
        for (int i = 0; i < MAX_VEC; i++) begin
            if (oh[i]) r = VEC_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/msi_cfg_space.sv
module msi_cfg_space
    import msi_pkg::*;
#(
    parameter bit ADDR64   = 1'b1,
    parameter bit MASKABLE = 1'b1,
    parameter int VEC_LOG2 = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [5:0]         cfg_dw,
    input  logic [3:0]         cfg_be,
    input  logic [31:0]        cfg_wdata,
    input  logic [MAX_VEC-1:0] pend_i,
    output logic [31:0]        cfg_rdata,
    output logic               en_o,
    output logic [2:0]         enl_o,
    output logic [63:0]        addr_o,
    output logic [15:0]        dat_o,
    output logic [MAX_VEC-1:0] mask_o,
    output logic               replay_o
);

    localparam int                 NVEC    = 1 << VEC_LOG2;
    localparam logic [7:0]         LEN     = cap_len(ADDR64, MASKABLE);
    localparam logic [7:0]         OFF_ALO = 8'h04;
    localparam logic [7:0]         OFF_AHI = 8'h08;
    localparam logic [7:0]         OFF_DAT = ADDR64 ? 8'h0C : 8'h08;
    localparam logic [7:0]         OFF_MSK = ADDR64 ? 8'h10 : 8'h0C;
    localparam logic [7:0]         OFF_PND = ADDR64 ? 8'h14 : 8'h10;
    localparam logic [2:0]         CAP     = 3'(VEC_LOG2);
    localparam logic [MAX_VEC-1:0] IMPL    = {MAX_VEC{1'b1}} >> (MAX_VEC - NVEC);

    cfg_st_t     q, d;
    logic [7:0]  byte_off;
    logic        in_range;
    logic [15:0] ctrl_w;
    logic [31:0] merged;

    assign byte_off = {cfg_dw, 2'b00};
    assign in_range = byte_off < LEN;
    assign ctrl_w   = {7'd0, MASKABLE, ADDR64, q.enl, CAP, q.en};

    always_comb begin
        d      = q;
        d.trig = 1'b0;
        merged = '0;
        if (cfg_wr && in_range) begin
            if (byte_off == 8'h00) begin
                if (cfg_be[2]) begin
                    d.en  = cfg_wdata[16];
                    d.enl = (cfg_wdata[22:20] > CAP) ? CAP : cfg_wdata[22:20];
                end
                d.trig = cfg_be[2] | cfg_be[3];
            end else if (byte_off == OFF_ALO) begin
                merged = byte_merge({q.alo, 2'b00}, cfg_wdata, cfg_be);
                d.alo  = merged[31:2];
            end else if (ADDR64 && byte_off == OFF_AHI) begin
                d.ahi = byte_merge(q.ahi, cfg_wdata, cfg_be);
            end else if (byte_off == OFF_DAT) begin
                merged = byte_merge({16'h0000, q.dat}, cfg_wdata, {2'b00, cfg_be[1:0]});
                d.dat  = merged[15:0];
            end else if (MASKABLE && byte_off == OFF_MSK) begin
                d.mask = byte_merge(q.mask, cfg_wdata, cfg_be) & IMPL;
                d.trig = |cfg_be;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (in_range) begin
            if (byte_off == 8'h00)                        cfg_rdata = {ctrl_w, 16'h0005};
            else if (byte_off == OFF_ALO)                 cfg_rdata = {q.alo, 2'b00};
            else if (ADDR64 && byte_off == OFF_AHI)       cfg_rdata = q.ahi;
            else if (byte_off == OFF_DAT)                 cfg_rdata = {16'h0000, q.dat};
            else if (MASKABLE && byte_off == OFF_MSK)     cfg_rdata = q.mask;
            else if (MASKABLE && byte_off == OFF_PND)     cfg_rdata = pend_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en_o     = q.en;
    assign enl_o    = q.enl;
    assign addr_o   = ADDR64 ? {q.ahi, q.alo, 2'b00} : {32'h0, q.alo, 2'b00};
    assign dat_o    = q.dat;
    assign mask_o   = q.mask;
    assign replay_o = q.trig;

endmodule

// File: rtl/msi_vec_tracker.sv
module msi_vec_tracker
    import msi_pkg::*;
#(
    parameter bit MASKABLE = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_i,
    input  logic [VEC_W-1:0]   vec_i,
    input  logic               en_i,
    input  logic [2:0]         enl_i,
    input  logic [MAX_VEC-1:0] mask_i,
    input  logic               replay_i,
    input  logic [MAX_VEC-1:0] grant_i,
    output logic [MAX_VEC-1:0] pend_o,
    output logic [MAX_VEC-1:0] queue_o,
    output logic               err_o
);

    trk_st_t            q, d;
    logic [VEC_W:0]     lim;
    logic               legal;
    logic               masked;
    logic [MAX_VEC-1:0] move;

    assign lim    = (VEC_W+1)'(1) << enl_i;
    assign legal  = {1'b0, vec_i} < lim;
    assign masked = MASKABLE && mask_i[vec_i];

    always_comb begin
        d       = q;
        d.queue = q.queue & ~grant_i;
        move    = '0;
        if (irq_i && en_i) begin
            if (!legal)      d.err          = 1'b1;
            else if (masked) d.pend[vec_i]  = 1'b1;
            else             d.queue[vec_i] = 1'b1;
        end
        if (MASKABLE && replay_i && en_i) begin
            move    = d.pend & ~mask_i;
            d.pend  = d.pend & ~move;
            d.queue = d.queue | move;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend_o  = q.pend;
    assign queue_o = q.queue;
    assign err_o   = q.err;

    p_masked_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i && en_i && legal && MASKABLE && mask_i[vec_i]) |=> q.pend[$past(vec_i)]);

    p_no_intake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> (((q.queue & ~$past(q.queue)) == '0) && ((q.pend & ~$past(q.pend)) == '0)));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |=> q.err);

endmodule

// File: rtl/msi_lowest_pick.sv
module msi_lowest_pick #(
    parameter int W = 32
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] grant,
    output logic         any
);

    logic [W-1:0] below;

    assign below[0] = 1'b0;
    for (genvar i = 1; i < W; i++) begin : g_chain
        assign below[i] = below[i-1] | req[i-1];
    end

    assign grant = req & ~below;
    assign any   = |req;

endmodule

// File: rtl/msi_msg_port.sv
module msi_msg_port
    import msi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ready_i,
    input  logic             any_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic [63:0]      addr_i,
    input  logic [15:0]      dat_i,
    input  logic [2:0]       enl_i,
    output logic             valid_o,
    output logic [63:0]      addr_o,
    output logic [31:0]      data_o,
    output logic             load_o
);

    msg_st_t     q, d;
    logic [15:0] lowmask;
    logic        free;

    assign free    = !q.valid || ready_i;
    assign load_o  = any_i && free;
    assign lowmask = 16'((17'd1 << enl_i) - 17'd1);

    always_comb begin
        d = q;
        if (free) begin
            d.valid = any_i;
            if (any_i) begin
                d.addr = addr_i;
                d.data = {16'h0000, (dat_i & ~lowmask) | {11'd0, vec_i}};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid_o = q.valid;
    assign addr_o  = q.addr;
    assign data_o  = q.data;

    p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && !ready_i) |=> (q.valid && $stable(q.addr) && $stable(q.data)));

endmodule

// File: rtl/msi_cap_dispatch.sv
module msi_cap_dispatch
    import msi_pkg::*;
#(
    parameter bit ADDR64   = 1'b1,
    parameter bit MASKABLE = 1'b1,
    parameter int VEC_LOG2 = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [5:0]  cfg_dw,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        irq_valid,
    input  logic [4:0]  irq_vec,
    output logic        msg_valid,
    input  logic        msg_ready,
    output logic [63:0] msg_addr,
    output logic [31:0] msg_data,
    output logic        vec_err
);

    logic               en_w;
    logic [2:0]         enl_w;
    logic [63:0]        addr_w;
    logic [15:0]        dat_w;
    logic [MAX_VEC-1:0] mask_w;
    logic               replay_w;
    logic [MAX_VEC-1:0] pend_w;
    logic [MAX_VEC-1:0] queue_w;
    logic [MAX_VEC-1:0] grant_raw;
    logic [MAX_VEC-1:0] grant_eff;
    logic               any_w;
    logic               load_w;

    msi_cfg_space #(
        .ADDR64   (ADDR64),
        .MASKABLE (MASKABLE),
        .VEC_LOG2 (VEC_LOG2)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_dw    (cfg_dw),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .pend_i    (pend_w),
        .cfg_rdata (cfg_rdata),
        .en_o      (en_w),
        .enl_o     (enl_w),
        .addr_o    (addr_w),
        .dat_o     (dat_w),
        .mask_o    (mask_w),
        .replay_o  (replay_w)
    );

    msi_vec_tracker #(
        .MASKABLE (MASKABLE)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_i    (irq_valid),
        .vec_i    (irq_vec),
        .en_i     (en_w),
        .enl_i    (enl_w),
        .mask_i   (mask_w),
        .replay_i (replay_w),
        .grant_i  (grant_eff),
        .pend_o   (pend_w),
        .queue_o  (queue_w),
        .err_o    (vec_err)
    );

    msi_lowest_pick #(
        .W (MAX_VEC)
    ) u_pick (
        .req   (queue_w),
        .grant (grant_raw),
        .any   (any_w)
    );

    msi_msg_port u_msg (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready_i (msg_ready),
        .any_i   (any_w),
        .vec_i   (onehot_index(grant_raw)),
        .addr_i  (addr_w),
        .dat_i   (dat_w),
        .enl_i   (enl_w),
        .valid_o (msg_valid),
        .addr_o  (msg_addr),
        .data_o  (msg_data),
        .load_o  (load_w)
    );

    assign grant_eff = load_w ? grant_raw : '0;

    p_grant_in_queue_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_raw) && ((grant_raw & ~queue_w) == '0));

endmodule

// File: tb/tb_msi_cap_dispatch.sv
module tb_msi_cap_dispatch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq_valid = 1'b0;
    logic [4:0]  irq_vec = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;
    logic        vec_err;

    int nchk = 0;
    int nerr = 0;

    logic [31:0] got_data[$];
    logic [63:0] got_addr[$];

    // model state
    bit          m_en, m_trig, m_mv, m_err;
    int          m_enl;
    logic [31:0] m_alo, m_ahi, m_mask, m_pend, m_queue, m_mdata;
    logic [15:0] m_dat;
    logic [63:0] m_maddr;

    msi_cap_dispatch dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_valid(irq_valid),
        .irq_vec(irq_vec), .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data), .vec_err(vec_err)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r = o;
        for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = n[8*i +: 8];
        return r;
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        logic [31:0] qn, mv;
        bit          tn;
        int          v;
        if (!rst_n) begin
            m_en = 0; m_trig = 0; m_mv = 0; m_err = 0; m_enl = 0;
            m_alo = 0; m_ahi = 0; m_mask = 0; m_pend = 0; m_queue = 0;
            m_dat = 0; m_mdata = 0; m_maddr = 0;
        end else begin
            qn = m_queue;
            if (!m_mv || msg_ready) begin
                if (m_queue != 0) begin
                    v = 0;
                    for (int i = 31; i >= 0; i--) if (m_queue[i]) v = i;
                    qn[v]   = 1'b0;
                    m_mv    = 1;
                    m_maddr = {m_ahi, m_alo};
                    m_mdata = {16'h0, (m_dat & ~16'((1 << m_enl) - 1)) | 16'(v)};
                end else m_mv = 0;
            end
            if (irq_valid && m_en) begin
                if (int'(irq_vec) >= (1 << m_enl)) m_err = 1;
                else if (m_mask[irq_vec])          m_pend[irq_vec] = 1'b1;
                else                               qn[irq_vec] = 1'b1;
            end
            if (m_trig && m_en) begin
                mv = m_pend & ~m_mask;
                m_pend = m_pend & ~mv;
                qn = qn | mv;
            end
            m_queue = qn;
            tn = 0;
            if (cfg_wr) begin
                case (cfg_dw)
                    6'd0: begin
                        if (cfg_be[2]) begin
                            m_en  = cfg_wdata[16];
                            m_enl = (cfg_wdata[22:20] > 3) ? 3 : int'(cfg_wdata[22:20]);
                        end
                        tn = cfg_be[2] | cfg_be[3];
                    end
                    6'd1: m_alo = merge(m_alo, cfg_wdata, cfg_be) & 32'hFFFF_FFFC;
                    6'd2: m_ahi = merge(m_ahi, cfg_wdata, cfg_be);
                    6'd3: m_dat = 16'(merge({16'h0, m_dat}, cfg_wdata, {2'b00, cfg_be[1:0]}));
                    6'd4: begin m_mask = merge(m_mask, cfg_wdata, cfg_be) & 32'hFF; tn = |cfg_be; end
                    default: ;
                endcase
            end
            m_trig = tn;
        end
    end

    // sample between the driving edge and the next rising edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk("R11 msg_valid vs model", msg_valid, m_mv);
            if (m_mv) begin
                chk("R13 msg_addr vs model", msg_addr, m_maddr);
                chk("R6 msg_data vs model", msg_data, m_mdata);
            end
            chk("R9 vec_err vs model", vec_err, m_err);
            if (msg_valid && msg_ready) begin
                got_data.push_back(msg_data);
                got_addr.push_back(msg_addr);
            end
        end
    end

    task automatic wr(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] dat);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = dat;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic rd(input logic [5:0] dw, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_dw = dw;
        #1;
        chk(tag, {32'h0, cfg_rdata}, {32'h0, exp});
    endtask

    task automatic irq(input logic [4:0] v);
        @(negedge clk);
        irq_valid = 1'b1; irq_vec = v;
        @(negedge clk);
        irq_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        nerr++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(0, 32'h0186_0005, "R1 control after reset");
        rd(1, 32'h0, "R1 addr lo");
        rd(2, 32'h0, "R1 addr hi");
        rd(3, 32'h0, "R1 data");
        rd(4, 32'h0, "R1 mask");
        rd(5, 32'h0, "R1 pending");
        chk("R1 msg_valid", msg_valid, 0);
        chk("R1 vec_err", vec_err, 0);
        // R4 beyond capability length
        rd(6, 32'h0, "R4 read beyond length");
        wr(6, 4'hF, 32'hFFFF_FFFF);
        rd(6, 32'h0, "R4 write beyond length ignored");
        rd(15, 32'h0, "R4 far read");
        // R2 control writes
        wr(0, 4'hF, 32'hFFFF_FFFF);
        rd(0, 32'h01B7_0005, "R2 enable and clamped count");
        wr(0, 4'b0100, 32'h0020_0000);
        rd(0, 32'h01A6_0005, "R2 disable count 2");
        wr(0, 4'b1000, 32'hFF00_0000);
        rd(0, 32'h01A6_0005, "R2 upper control byte read-only");
        // R3 register fields
        wr(1, 4'hF, 32'hFFFF_FFFF);
        rd(1, 32'hFFFF_FFFC, "R3 addr lo low bits zero");
        wr(1, 4'hF, 32'h1234_5678);
        wr(2, 4'hF, 32'hDEAD_BEEF);
        rd(2, 32'hDEAD_BEEF, "R3 addr hi");
        wr(3, 4'hF, 32'hFFFF_ABCD);
        rd(3, 32'h0000_ABCD, "R3 data 16 bit");
        wr(4, 4'hF, 32'hFFFF_FFFF);
        rd(4, 32'h0000_00FF, "R3 mask implemented bits");
        wr(4, 4'hF, 32'h0);
        wr(5, 4'hF, 32'hFFFF_FFFF);
        rd(5, 32'h0, "R3 pending read-only");
        // R10 disabled drop
        irq(0);
        idle(4);
        chk("R10 no message while disabled", got_data.size(), 0);
        chk("R10 no error while disabled", vec_err, 0);
        wr(0, 4'b0100, 32'h0021_0000);
        idle(4);
        chk("R10 request not kept", got_data.size(), 0);
        // R5 latency, R6 data, R13 address
        irq(2);
        #1 chk("R5 not yet valid", msg_valid, 0);
        @(negedge clk);
        #1 chk("R5 valid after second edge", msg_valid, 1);
        idle(3);
        chk("R5 one message", got_data.size(), 1);
        chk("R6 vector in low bits", got_data[0], 32'h0000_ABCE);
        chk("R13 64-bit address", got_addr[0], 64'hDEAD_BEEF_1234_5678);
        got_data.delete(); got_addr.delete();
        // R11 hold, R12 order and merge
        @(negedge clk); msg_ready = 1'b0;
        irq(3); irq(1); irq(3); irq(3);
        idle(3);
        chk("R11 held valid", msg_valid, 1);
        chk("R11 held data", msg_data, 32'h0000_ABCF);
        @(negedge clk); msg_ready = 1'b1;
        idle(6);
        chk("R12 merged count", got_data.size(), 3);
        if (got_data.size() == 3) begin
            chk("R12 first", got_data[0], 32'h0000_ABCF);
            chk("R12 lowest next", got_data[1], 32'h0000_ABCD);
            chk("R12 last", got_data[2], 32'h0000_ABCF);
        end
        got_data.delete(); got_addr.delete();
        // R7 masked, R8 replay via mask write
        wr(4, 4'hF, 32'h0000_000A);
        irq(1); irq(3);
        idle(3);
        chk("R7 no message when masked", got_data.size(), 0);
        rd(5, 32'h0000_000A, "R7 pending bits");
        wr(4, 4'hF, 32'h0);
        idle(6);
        chk("R8 replay count", got_data.size(), 2);
        if (got_data.size() == 2) begin
            chk("R8 ascending first", got_data[0], 32'h0000_ABCD);
            chk("R8 ascending second", got_data[1], 32'h0000_ABCF);
        end
        rd(5, 32'h0, "R8 pending cleared");
        got_data.delete(); got_addr.delete();
        // R8 replay needs enable; control write triggers it
        wr(4, 4'hF, 32'h0000_0004);
        irq(2);
        idle(2);
        rd(5, 32'h0000_0004, "R7 pending vector 2");
        wr(0, 4'b0100, 32'h0020_0000);
        wr(4, 4'hF, 32'h0);
        idle(4);
        chk("R8 no replay while disabled", got_data.size(), 0);
        rd(5, 32'h0000_0004, "R8 pending kept while disabled");
        wr(0, 4'b0100, 32'h0021_0000);
        idle(5);
        chk("R8 control write replays", got_data.size(), 1);
        if (got_data.size() == 1) chk("R8 replayed data", got_data[0], 32'h0000_ABCE);
        rd(5, 32'h0, "R8 pending cleared by control write");
        got_data.delete(); got_addr.delete();
        // R9 illegal vector
        irq(4);
        idle(4);
        chk("R9 illegal dropped", got_data.size(), 0);
        chk("R9 error raised", vec_err, 1);
        irq(0);
        idle(4);
        chk("R9 error sticky", vec_err, 1);
        chk("R9 legal still sent", got_data.size(), 1);
        if (got_data.size() == 1) chk("R6 vector 0 data", got_data[0], 32'h0000_ABCC);
        got_data.delete(); got_addr.delete();
        // R6 single vector and eight vectors
        wr(0, 4'b0100, 32'h0001_0000);
        irq(0);
        idle(4);
        irq(1);
        idle(4);
        chk("R6 single vector one message", got_data.size(), 1);
        if (got_data.size() == 1) chk("R6 single vector data untouched", got_data[0], 32'h0000_ABCD);
        got_data.delete(); got_addr.delete();
        wr(0, 4'b0100, 32'h0031_0000);
        irq(7);
        idle(4);
        chk("R6 eight vectors count", got_data.size(), 1);
        if (got_data.size() == 1) chk("R6 three low bits replaced", got_data[0], 32'h0000_ABCF);
        idle(2);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule